// File: doc/BRIEF.md
# Write-Cycle Status Read Path

This block sits on the read side of a byte-wide flash-style memory. It decides what byte goes onto the data bus. While no internal write cycle is running, a read returns the array contents unchanged. While a page program or a chip erase is running, two bits of every read become status bits, so the host can poll for completion without any separate status register.

Bit 7 is the polling bit. It carries the inverse of bit 7 of a reference byte. For a page program the reference is the last byte that was loaded. For a chip erase the reference is all ones, so bit 7 reads as 0 until the erase is done. Bit 6 is the toggle bit. It changes value once at the start of every read access, and only while the write cycle runs. The remaining bits always come from the array.

The bus is driven only while both active-low chip and output enables are asserted. At all other times the driven value is forced to zero and the enable output is low. Once the busy flag drops, all eight bits return to the array data in the same cycle.

Top module: `prog_status_read`

## Requirements
- R1: `busDrive` is 1 exactly when `ceN` and `oeN` are both 0. Otherwise it is 0.
- R2: Whenever `busDrive` is 0, `busData` is 0x00.
- R3: While `busy`=1 and `eraseMode`=0, a driven read shows bit 7 as the inverse of `lastData[7]`.
- R4: While `busy`=1 and `eraseMode`=1, a driven read shows bit 7 as 0, which is the inverse of an all-ones reference, whatever `lastData` holds.
- R5: While `busy`=1, bit 6 of a driven read changes value once per read access. A read access starts on the first clock edge that sees `ceN`=0 and `oeN`=0 after an edge where they were not both 0. After reset, the first read of a busy interval shows bit 6 = 1.
- R6: Bit 6 holds its value for as long as a single read access stays active, however many clocks that is.
- R7: While `busy`=0, a driven read returns `arrayData` on all bits. When `busy` falls during an active read, the bus shows `arrayData` in that same cycle, with no clock edge needed.
- R8: Bits 5 to 0 of a driven read always equal `arrayData[5:0]`, whether or not `busy` is set.
- R9: The toggle state clears whenever `busy` is 0. The first read of every new busy interval shows bit 6 = 1 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busy | input | 1 | Internal program or erase cycle running |
| eraseMode | input | 1 | Running cycle is a chip erase (reference byte is all ones) |
| lastData | input | 8 | Last byte loaded into the page buffer |
| arrayData | input | 8 | Array read data at the current read address |
| ceN | input | 1 | Chip enable, active low |
| oeN | input | 1 | Output enable, active low |
| busData | output | 8 | Byte for the data bus pads |
| busDrive | output | 1 | Pad output enable |

## Verification
The enable output, the polling bit, the low bits and the return to array data on a falling busy flag all follow the inputs combinationally. The bench checks these one time step after driving the inputs on a falling clock edge, with no clock edge in between.

The toggle bit is the only registered result. It changes on the first rising edge that sees an active read. Every read task therefore holds the enables for two rising edges and samples on the following falling edge.

To show that the toggle bit does not advance per clock, one read is held for several cycles and sampled more than once. Each read task compares bit 6 against the value the bench predicts from its own count of read accesses within the current busy interval.

// File: rtl/prog_status_pkg.sv
package prog_status_pkg;

  // Strobes passed from the control to the datapath
  typedef struct packed {
    logic driveEn;    // both enables active
    logic statusSel;  // write cycle running: substitute status bits
    logic eraseRef;   // reference byte is all ones
    logic toggleVal;  // current toggle-bit value
  } statusCtl_t;

endpackage

// File: rtl/prog_status_ctrl.sv
module prog_status_ctrl
  import prog_status_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       busy,
  input  logic       eraseMode,
  input  logic       ceN,
  input  logic       oeN,
  output statusCtl_t ctl
);

  logic readAct;
  logic readActQ;
  logic toggleQ;
  logic readStart;

  assign readAct   = !ceN && !oeN;
  assign readStart = readAct && !readActQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readActQ <= 1'b0;
      toggleQ  <= 1'b0;
    end else begin
      readActQ <= readAct;
      if (!busy)
        toggleQ <= 1'b0;
      else if (readStart)
        toggleQ <= ~toggleQ;
    end
  end

  always_comb begin
    ctl.driveEn   = readAct;
    ctl.statusSel = busy;
    ctl.eraseRef  = eraseMode;
    ctl.toggleVal = toggleQ;
  end

endmodule

// File: rtl/prog_status_dp.sv
module prog_status_dp
  import prog_status_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int POLL_BIT   = 7,
  parameter int TOGGLE_BIT = 6
) (
  input  statusCtl_t        ctl,
  input  logic [DATA_W-1:0] lastData,
  input  logic [DATA_W-1:0] arrayData,
  output logic [DATA_W-1:0] busData
);

  localparam logic [DATA_W-1:0] ERASE_REF = '1;

  logic [DATA_W-1:0] refByte;
  logic [DATA_W-1:0] statusByte;
  logic [DATA_W-1:0] chosenByte;
  logic              unusedRefBits;

  assign refByte       = ctl.eraseRef ? ERASE_REF : lastData;
  assign unusedRefBits = ^refByte;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if (i == POLL_BIT) begin : g_poll
      assign statusByte[i] = ~refByte[i];
    end else if (i == TOGGLE_BIT) begin : g_tog
      assign statusByte[i] = ctl.toggleVal;
    end else begin : g_pass
      assign statusByte[i] = arrayData[i];
    end
  end

  assign chosenByte = ctl.statusSel ? statusByte : arrayData;
  assign busData    = ctl.driveEn ? chosenByte : '0;

endmodule

// File: rtl/prog_status_read.sv
module prog_status_read
  import prog_status_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int POLL_BIT   = 7,
  parameter int TOGGLE_BIT = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busy,
  input  logic              eraseMode,
  input  logic [DATA_W-1:0] lastData,
  input  logic [DATA_W-1:0] arrayData,
  input  logic              ceN,
  input  logic              oeN,
  output logic [DATA_W-1:0] busData,
  output logic              busDrive
);

  statusCtl_t ctl;

  prog_status_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .busy      (busy),
    .eraseMode (eraseMode),
    .ceN       (ceN),
    .oeN       (oeN),
    .ctl       (ctl)
  );

  prog_status_dp #(
    .DATA_W     (DATA_W),
    .POLL_BIT   (POLL_BIT),
    .TOGGLE_BIT (TOGGLE_BIT)
  ) u_dp (
    .ctl       (ctl),
    .lastData  (lastData),
    .arrayData (arrayData),
    .busData   (busData)
  );

  assign busDrive = ctl.driveEn;

endmodule

// File: rtl/prog_status_read_chk.sv
module prog_status_read_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              eraseMode,
  input logic [DATA_W-1:0] lastData,
  input logic [DATA_W-1:0] arrayData,
  input logic              ceN,
  input logic              oeN,
  input logic [DATA_W-1:0] busData,
  input logic              busDrive
);

  logic readAct;
  assign readAct = !ceN && !oeN;

  a_r2_quiet_bus: assert property (@(posedge clk) disable iff (!rstN)
    !busDrive |-> busData == '0);

  a_r3_poll_program: assert property (@(posedge clk) disable iff (!rstN)
    (busDrive && busy && !eraseMode) |-> busData[7] == !lastData[7]);

  a_r4_poll_erase: assert property (@(posedge clk) disable iff (!rstN)
    (busDrive && busy && eraseMode) |-> busData[7] == 1'b0);

  a_r6_toggle_held: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && readAct && $past(readAct) && $past(readAct, 2))
      |-> $stable(busData[6]));

  a_r7_idle_pass: assert property (@(posedge clk) disable iff (!rstN)
    (busDrive && !busy) |-> busData == arrayData);

  a_r8_low_bits: assert property (@(posedge clk) disable iff (!rstN)
    busDrive |-> busData[5:0] == arrayData[5:0]);

endmodule

bind prog_status_read prog_status_read_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busy      (busy),
  .eraseMode (eraseMode),
  .lastData  (lastData),
  .arrayData (arrayData),
  .ceN       (ceN),
  .oeN       (oeN),
  .busData   (busData),
  .busDrive  (busDrive)
);

// File: tb/prog_status_read_bench.sv
module prog_status_read_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busy = 1'b0;
  logic       eraseMode = 1'b0;
  logic [7:0] lastData = 8'h00;
  logic [7:0] arrayData = 8'h00;
  logic       ceN = 1'b1;
  logic       oeN = 1'b1;
  logic [7:0] busData;
  logic       busDrive;

  int errors = 0;
  int checks = 0;
  logic expTog = 1'b0;  // bench model of the toggle bit

  always #10 clk = ~clk;  // 50 MHz

  prog_status_read u_prog_status_read (
    .clk       (clk),
    .rstN      (rstN),
    .busy      (busy),
    .eraseMode (eraseMode),
    .lastData  (lastData),
    .arrayData (arrayData),
    .ceN       (ceN),
    .oeN       (oeN),
    .busData   (busData),
    .busDrive  (busDrive)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One read access of two clocks; returns the sampled bus byte.
  task automatic doRead(output logic [7:0] got);
    @(negedge clk);
    ceN = 1'b0;
    oeN = 1'b0;
    repeat (2) @(negedge clk);
    got = busData;
    check("R1 drive during read", {7'b0, busDrive}, 8'h01);
    ceN = 1'b1;
    oeN = 1'b1;
    @(negedge clk);
  endtask

  task automatic testReset();
    @(negedge clk);
    check("R1 reset no drive", {7'b0, busDrive}, 8'h00);
    check("R2 reset bus zero", busData, 8'h00);
  endtask

  task automatic testEnables();
    @(negedge clk);
    arrayData = 8'h5A;
    ceN = 1'b0;
    oeN = 1'b1;
    #1;
    check("R1 only ce low", {7'b0, busDrive}, 8'h00);
    check("R2 only ce low", busData, 8'h00);
    ceN = 1'b1;
    oeN = 1'b0;
    #1;
    check("R1 only oe low", {7'b0, busDrive}, 8'h00);
    check("R2 only oe low", busData, 8'h00);
    oeN = 1'b1;
  endtask

  task automatic testIdle();
    logic [7:0] got;
    arrayData = 8'hC3;
    doRead(got);
    check("R7 idle read", got, 8'hC3);
  endtask

  task automatic testProgram();
    logic [7:0] got;
    @(negedge clk);
    busy = 1'b1;
    eraseMode = 1'b0;
    expTog = 1'b0;
    lastData = 8'h80;
    arrayData = 8'h2B;
    for (int k = 0; k < 4; k++) begin
      doRead(got);
      expTog = ~expTog;
      check("R3 poll bit", {7'b0, got[7]}, 8'h00);
      check("R5 toggle bit", {7'b0, got[6]}, {7'b0, expTog});
      check("R8 low bits", {2'b0, got[5:0]}, 8'h2B);
    end
    lastData = 8'h11;
    arrayData = 8'h95;
    doRead(got);
    expTog = ~expTog;
    check("R3 poll bit inv", {7'b0, got[7]}, 8'h01);
    check("R8 low bits b", {2'b0, got[5:0]}, 8'h15);
  endtask

  task automatic testLongRead();
    logic [7:0] first;
    @(negedge clk);
    ceN = 1'b0;
    oeN = 1'b0;
    repeat (2) @(negedge clk);
    first = busData;
    expTog = ~expTog;
    check("R5 long read toggle", {7'b0, first[6]}, {7'b0, expTog});
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R6 held toggle", {7'b0, busData[6]}, {7'b0, expTog});
    end
    // busy falls during the read: array data immediately
    arrayData = 8'h4E;
    busy = 1'b0;
    #1;
    check("R7 busy drop same cycle", busData, 8'h4E);
    @(negedge clk);
    ceN = 1'b1;
    oeN = 1'b1;
    @(negedge clk);
  endtask

  task automatic testErase();
    logic [7:0] got;
    @(negedge clk);
    busy = 1'b1;
    eraseMode = 1'b1;
    lastData = 8'h00;
    arrayData = 8'hFF;
    doRead(got);
    check("R4 erase poll", {7'b0, got[7]}, 8'h00);
    check("R9 restart toggle", {7'b0, got[6]}, 8'h01);
    doRead(got);
    check("R5 erase toggle", {7'b0, got[6]}, 8'h00);
    @(negedge clk);
    busy = 1'b0;
    eraseMode = 1'b0;
    doRead(got);
    check("R7 after erase", got, 8'hFF);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testEnables();
    testIdle();
    testProgram();
    testLongRead();
    testErase();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule